// File: doc/BRIEF.md
# GPIO register bank with change interrupt

This block is the register core of a general-purpose parallel port. It holds three
writable registers: output levels, readback inversion mask and pin direction. From
these it drives per-pin output data and output-enable signals toward the pad ring. It
also presents an input view of the pins, with polarity adjusted, for readback. A bus
front end supplies a write strobe, a read strobe, a 2-bit register index and write data.
The block returns read data combinationally for the selected index.

The block watches pins configured as inputs for change. A baseline snapshot of the raw
pin levels is kept, and it is reloaded each time the input view is read. When any
input-direction pin differs from the snapshot, a registered interrupt request asserts.
It drops again when the pins return to the snapshot, or when the input view is read.
The request is an output-enable for an open-drain pad, so a high value means the shared
line is pulled low. The pin bus is assumed to be synchronized already.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output register reads 0xFF, the inversion register 0x00 and the direction register 0xFF. pad_oe_o is all zeros and irq_oe_o is 0.
- R2: A write strobe with index 1 (output), 2 (inversion) or 3 (direction) stores wdata_i at the next clock edge. A later read of that index returns the stored value.
- R3: A direction bit of 1 makes the pin an input, so its pad_oe_o bit is 0. A direction bit of 0 makes it an output with pad_oe_o at 1. pad_out_o always presents the output register.
- R4: Index 1 reads back the stored output register, whatever level is on pin_i.
- R5: Index 0 reads back pin_i XOR the inversion register for every pin, whatever its direction.
- R6: A write with index 0 changes no register: the readback of indices 1, 2 and 3 is unchanged.
- R7: When a pin configured as an input differs from the snapshot, irq_oe_o goes to 1 one clock edge later.
- R8: A difference on a pin configured as an output does not assert irq_oe_o.
- R9: irq_oe_o returns to 0 one edge after the pins return to the snapshot value.
- R10: A read strobe with index 0 clears irq_oe_o at the next edge and reloads the snapshot from the raw pins. The comparison ignores the inversion register.
- R11: Turning an output pin into an input asserts irq_oe_o when its level differs from the snapshot.
- R12: The first clock edge after reset loads the snapshot from pin_i without raising irq_oe_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | WIDTH | Synchronized pin levels |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| idx_i | input | 2 | Register index (0 input, 1 output, 2 inversion, 3 direction) |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data for idx_i |
| pad_out_o | output | WIDTH | Output data to the pads |
| pad_oe_o | output | WIDTH | Output enable per pad, 1 drives |
| irq_oe_o | output | 1 | Interrupt pad enable, 1 pulls the line low |

## Verification
The bench builds the block with the default WIDTH of 8. At that width, full-byte values
such as 0xA5 and 0x5A reach every bit lane. Mixed direction masks then place input and
output pins side by side, so any cross-lane leakage in the interrupt compare would show.
The width is small enough that each direction and inversion combination in the
scenarios can be predicted by hand.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_INV = 2'd2,
    REG_DIR = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] out_q_o,
  output logic [WIDTH-1:0] inv_q_o,
  output logic [WIDTH-1:0] dir_q_o
);
  localparam logic [WIDTH-1:0] OUT_RST = '1;
  localparam logic [WIDTH-1:0] INV_RST = '0;
  localparam logic [WIDTH-1:0] DIR_RST = '1;

  logic we_out, we_inv, we_dir;

  always_comb begin
    we_out = wr_i && (reg_idx_e'(idx_i) == REG_OUT);
    we_inv = wr_i && (reg_idx_e'(idx_i) == REG_INV);
    we_dir = wr_i && (reg_idx_e'(idx_i) == REG_DIR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o <= OUT_RST;
      inv_q_o <= INV_RST;
      dir_q_o <= DIR_RST;
    end else begin
      if (we_out) out_q_o <= wdata_i;
      if (we_inv) inv_q_o <= wdata_i;
      if (we_dir) dir_q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] out_q_i,
  input  logic [WIDTH-1:0] inv_q_i,
  input  logic [WIDTH-1:0] dir_q_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] in_view;

  for (genvar b = 0; b < WIDTH; b++) begin : g_inv
    assign in_view[b] = pin_i[b] ^ inv_q_i[b];
  end

  always_comb begin
    unique case (reg_idx_e'(idx_i))
      REG_IN:  rdata_o = in_view;
      REG_OUT: rdata_o = out_q_i;
      REG_INV: rdata_o = inv_q_i;
      REG_DIR: rdata_o = dir_q_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chg_irq.sv
module gpio_bank_chg_irq #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] dir_q_i,
  input  logic             rd_in_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] snap_q;
  logic [WIDTH-1:0] diff;
  logic             primed_q;
  logic             irq_q;

  // raw compare, input-direction lanes only
  for (genvar b = 0; b < WIDTH; b++) begin : g_diff
    assign diff[b] = dir_q_i[b] & (pin_i[b] ^ snap_q[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q   <= '0;
      primed_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      if (!primed_q || rd_in_i) snap_q <= pin_i;
      irq_q <= primed_q && !rd_in_i && (|diff);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic             irq_oe_o
);
  logic [WIDTH-1:0] out_q, inv_q, dir_q;
  logic             rd_in;

  assign rd_in = rd_i && (reg_idx_e'(idx_i) == REG_IN);

  gpio_bank_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .idx_i   (idx_i),
    .wdata_i (wdata_i),
    .out_q_o (out_q),
    .inv_q_o (inv_q),
    .dir_q_o (dir_q)
  );

  gpio_bank_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .idx_i   (idx_i),
    .pin_i   (pin_i),
    .out_q_i (out_q),
    .inv_q_i (inv_q),
    .dir_q_i (dir_q),
    .rdata_o (rdata_o)
  );

  gpio_bank_chg_irq #(.WIDTH(WIDTH)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .dir_q_i (dir_q),
    .rd_in_i (rd_in),
    .irq_o   (irq_oe_o)
  );

  assign pad_out_o = out_q;
  assign pad_oe_o  = ~dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] pin_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [1:0]       idx_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic             irq_oe_o
);
  assert_out_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 2'd1) |=> (pad_out_o == $past(wdata_i)));

  assert_dir_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == 2'd3) |=> (pad_oe_o == ~$past(wdata_i)));

  assert_out_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && idx_i == 2'd1) |=> $stable(pad_out_o));

  assert_oe_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && idx_i == 2'd3) |=> $stable(pad_oe_o));

  assert_rd_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == 2'd0) |=> !irq_oe_o);

  // all pins driven and direction unchanged: no new request
  assert_out_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pad_oe_o && !wr_i && !irq_oe_o) |=> !irq_oe_o);
endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pin_i     (pin_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .idx_i     (idx_i),
  .wdata_i   (wdata_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .irq_oe_o  (irq_oe_o)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin = 8'hA5;
  logic         wr = 1'b0, rd = 1'b0;
  logic [1:0]   idx = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, pad_out, pad_oe;
  logic         irq_oe;
  int           total = 0, bad = 0;

  always #2 clk = ~clk;

  gpio_bank #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_i(wr), .rd_i(rd),
    .idx_i(idx), .wdata_i(wdata), .rdata_o(rdata), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .irq_oe_o(irq_oe)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] i, logic [W-1:0] d);
    @(negedge clk); wr = 1'b1; idx = i; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  function automatic logic [W-1:0] peek(logic [1:0] i);
    idx = i;
    return 'x;
  endfunction

  task automatic rd_val(logic [1:0] i, output logic [W-1:0] v);
    idx = i; #1 v = rdata;
  endtask

  task automatic rd_in_strobe();
    @(negedge clk); rd = 1'b1; idx = 2'd0;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd_val(2'd1, v); check("R1 out", v, 8'hFF);
    rd_val(2'd2, v); check("R1 inv", v, 8'h00);
    rd_val(2'd3, v); check("R1 dir", v, 8'hFF);
    check("R1 oe", pad_oe, 8'h00);
    check("R12 irq after baseline", {7'd0, irq_oe}, 8'h00);
  endtask

  task automatic t_write_dir();
    logic [W-1:0] v;
    wr_reg(2'd1, 8'h3C); rd_val(2'd1, v); check("R2 out", v, 8'h3C);
    check("R3 pad_out", pad_out, 8'h3C);
    wr_reg(2'd2, 8'h0F); rd_val(2'd2, v); check("R2 inv", v, 8'h0F);
    wr_reg(2'd3, 8'hF0); rd_val(2'd3, v); check("R2 dir", v, 8'hF0);
    check("R3 oe", pad_oe, 8'h0F);
    pin = 8'hC3; #1;
    rd_val(2'd1, v); check("R4 out not pin", v, 8'h3C);
    rd_val(2'd0, v); check("R5 input view", v, 8'hC3 ^ 8'h0F);
    wr_reg(2'd0, 8'h55);
    rd_val(2'd1, v); check("R6 out", v, 8'h3C);
    rd_val(2'd2, v); check("R6 inv", v, 8'h0F);
    rd_val(2'd3, v); check("R6 dir", v, 8'hF0);
  endtask

  task automatic t_irq();
    // setup: inv 0x0F, dir 0xF0, pin 0xC3, snapshot from pins
    rd_in_strobe();
    @(negedge clk); check("R10 clear after baseline read", {7'd0, irq_oe}, 8'h00);
    pin = 8'hC2;                       // output lane 0 toggles
    @(negedge clk); @(negedge clk);
    check("R8 output lane quiet", {7'd0, irq_oe}, 8'h00);
    pin = 8'h42;                       // input lane 7 toggles
    @(negedge clk); check("R7 input lane asserts", {7'd0, irq_oe}, 8'h01);
    pin = 8'hC2;
    @(negedge clk); check("R9 return clears", {7'd0, irq_oe}, 8'h00);
    pin = 8'h02;
    @(negedge clk); check("R7 second change", {7'd0, irq_oe}, 8'h01);
    rd_in_strobe();
    check("R10 read clears", {7'd0, irq_oe}, 8'h00);
    @(negedge clk); check("R10 snapshot reloaded", {7'd0, irq_oe}, 8'h00);
    wr_reg(2'd2, 8'hFF);               // inversion must not affect compare
    @(negedge clk); check("R10 raw compare", {7'd0, irq_oe}, 8'h00);
  endtask

  task automatic t_dir_switch();
    // snapshot 0x02, lane 0 output; drive lane 0 to 1 then make it input
    pin = 8'h03;
    @(negedge clk); @(negedge clk);
    check("R8 output differs quietly", {7'd0, irq_oe}, 8'h00);
    wr_reg(2'd3, 8'hF1);
    check("R3 oe after switch", pad_oe, 8'h0E);
    @(negedge clk); check("R11 switch raises", {7'd0, irq_oe}, 8'h01);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_dir();
    t_irq();
    t_dir_switch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule